// File: doc/BRIEF.md
# Synchronized Conversion Slave Controller

This block sits beside a converter that normally runs conversions picked by its own local arbitration. A partner converter, acting as master, can ask it to take part in a conversion that both sides start together. The master raises a request level and presents a bundle of settings: channel, resolution, external multiplexer code and group select, plus a flag that says whether a local conversion in progress may be dropped.

When the request is accepted, the controller captures the bundle, marks itself as a sync partner and stops launching local conversions. If a local conversion is running, it either aborts that conversion at once or lets it finish and reports its result normally, depending on the flag. It then checks that the master still wants the conversion. If so, it acknowledges, starts the shared conversion and raises a partner-busy flag. When the converter reports the end, it sends a completion pulse to the master. If the master has dropped the request by then, the controller goes back to normal work without converting.

Top module: `sync_slave_ctrl`

## Requirements
- R1: After a synchronous reset, every output is 0.
- R2: conv_chan_o, conv_res_o, conv_emux_o and conv_grp_o hold the values on the settings inputs in the cycle the request was accepted. Later changes on those inputs do not alter them.
- R3: While a request is pending, local arbitration is ignored and no local_start_o is issued. When sreq_i and arb_req_i arrive together on an idle converter, the request wins. arb_block_o is 1 from acceptance until the shared start or the withdrawal.
- R4: A request with cancel_en_i=1 that is accepted during a local conversion produces an abort_o pulse in the cycle after acceptance. That conversion never gives a res_valid_o pulse.
- R5: A request with cancel_en_i=0 that is accepted during a local conversion waits for conv_done_i. res_valid_o pulses for that conversion, and the shared start follows one cycle later.
- R6: While the shared conversion runs, a new request produces no abort_o and no ack_o, and partner_busy_o stays 1.
- R7: sync_busy_o is 1 from the cycle after acceptance until the completion pulse or the withdrawal.
- R8: If sreq_i is 0 at the check before the start, no ack_o is given and sync_busy_o clears. An unfinished local conversion then still reports its result.
- R9: ack_o and conv_start_o are single-cycle pulses in the same cycle. partner_busy_o rises and arb_block_o falls in that same cycle. For an idle converter or a cancelled local conversion, this comes two cycles after the request is sampled.
- R10: conv_done_i during the shared conversion gives a partner_done_o pulse one cycle later. partner_busy_o and sync_busy_o are 0 in that cycle.
- R11: If a local conv_done_i coincides with acceptance of a cancelling request, the result is delivered (res_valid_o) and no abort_o is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sreq_i | input | 1 | Sync request level from master |
| chan_i | input | CH_W | Requested channel |
| res_i | input | RES_W | Requested resolution |
| emux_i | input | EMUX_W | External multiplexer code |
| grp_i | input | GRP_W | Group select |
| cancel_en_i | input | 1 | 1: drop a running local conversion |
| arb_req_i | input | 1 | Local arbitration wants a conversion |
| conv_done_i | input | 1 | Converter reports end of current conversion |
| local_start_o | output | 1 | Start pulse for a local conversion |
| abort_o | output | 1 | Abort pulse for the local conversion |
| res_valid_o | output | 1 | Local result valid pulse |
| ack_o | output | 1 | Acknowledge pulse to master |
| conv_start_o | output | 1 | Start pulse for the shared conversion |
| conv_chan_o | output | CH_W | Latched channel |
| conv_res_o | output | RES_W | Latched resolution |
| conv_emux_o | output | EMUX_W | Latched multiplexer code |
| conv_grp_o | output | GRP_W | Latched group select |
| sync_busy_o | output | 1 | Module is a sync partner |
| partner_busy_o | output | 1 | Shared conversion running |
| partner_done_o | output | 1 | Completion pulse to master |
| arb_block_o | output | 1 | Local arbitration writes blocked |

## Verification
Two functions can land in the same cycle: a cancelling request can be accepted in the very cycle the local conversion reports its end. The bench provokes this by raising sreq_i with cancel_en_i=1 and conv_done_i at the same negative edge. It then expects res_valid_o without abort_o, followed by the shared start. A second overlap, request versus local arbitration on an idle converter, is provoked in every idle sweep case. It is judged by the absence of local_start_o. The sweep covers busy/idle, cancel on/off, withdraw/proceed and several wait lengths.

// File: rtl/sync_slave_pkg.sv
package sync_slave_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOCAL = 3'd1,
    ST_WAIT  = 3'd2,
    ST_START = 3'd3,
    ST_SYNC  = 3'd4
  } slv_state_t;
endpackage

// File: rtl/sync_req_latch.sv
module sync_req_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/sync_slave_fsm.sv
module sync_slave_fsm
  import sync_slave_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sreq_i,
  input  logic cancel_en_i,
  input  logic arb_req_i,
  input  logic conv_done_i,
  output logic load_o,
  output logic local_start_o,
  output logic abort_o,
  output logic res_valid_o,
  output logic start_o,
  output logic partner_done_o,
  output logic sync_busy_o,
  output logic partner_busy_o,
  output logic arb_block_o
);
  slv_state_t st, st_n;
  logic lstart_n, abort_n, rvalid_n, start_n, pdone_n;

  always_comb begin
    st_n     = st;
    load_o   = 1'b0;
    lstart_n = 1'b0;
    abort_n  = 1'b0;
    rvalid_n = 1'b0;
    start_n  = 1'b0;
    pdone_n  = 1'b0;
    case (st)
      ST_IDLE: begin
        if (sreq_i) begin
          load_o = 1'b1;
          st_n   = ST_START;
        end else if (arb_req_i) begin
          lstart_n = 1'b1;
          st_n     = ST_LOCAL;
        end
      end
      ST_LOCAL: begin
        if (sreq_i) begin
          load_o = 1'b1;
          if (conv_done_i) begin
            rvalid_n = 1'b1;
            st_n     = ST_START;
          end else if (cancel_en_i) begin
            abort_n = 1'b1;
            st_n    = ST_START;
          end else begin
            st_n = ST_WAIT;
          end
        end else if (conv_done_i) begin
          rvalid_n = 1'b1;
          st_n     = ST_IDLE;
        end
      end
      ST_WAIT: begin
        if (conv_done_i) begin
          rvalid_n = 1'b1;
          st_n     = sreq_i ? ST_START : ST_IDLE;
        end else if (!sreq_i) begin
          st_n = ST_LOCAL;
        end
      end
      ST_START: begin
        if (sreq_i) begin
          start_n = 1'b1;
          st_n    = ST_SYNC;
        end else begin
          st_n = ST_IDLE;
        end
      end
      ST_SYNC: begin
        if (conv_done_i) begin
          pdone_n = 1'b1;
          st_n    = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= ST_IDLE;
      local_start_o  <= 1'b0;
      abort_o        <= 1'b0;
      res_valid_o    <= 1'b0;
      start_o        <= 1'b0;
      partner_done_o <= 1'b0;
      sync_busy_o    <= 1'b0;
      partner_busy_o <= 1'b0;
      arb_block_o    <= 1'b0;
    end else begin
      st             <= st_n;
      local_start_o  <= lstart_n;
      abort_o        <= abort_n;
      res_valid_o    <= rvalid_n;
      start_o        <= start_n;
      partner_done_o <= pdone_n;
      sync_busy_o    <= (st_n == ST_WAIT) || (st_n == ST_START) || (st_n == ST_SYNC);
      partner_busy_o <= (st_n == ST_SYNC);
      arb_block_o    <= (st_n == ST_WAIT) || (st_n == ST_START);
    end
  end
endmodule

// File: rtl/sync_slave_ctrl.sv
module sync_slave_ctrl #(
  parameter int CH_W   = 4,
  parameter int RES_W  = 2,
  parameter int EMUX_W = 3,
  parameter int GRP_W  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sreq_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [RES_W-1:0]  res_i,
  input  logic [EMUX_W-1:0] emux_i,
  input  logic [GRP_W-1:0]  grp_i,
  input  logic              cancel_en_i,
  input  logic              arb_req_i,
  input  logic              conv_done_i,
  output logic              local_start_o,
  output logic              abort_o,
  output logic              res_valid_o,
  output logic              ack_o,
  output logic              conv_start_o,
  output logic [CH_W-1:0]   conv_chan_o,
  output logic [RES_W-1:0]  conv_res_o,
  output logic [EMUX_W-1:0] conv_emux_o,
  output logic [GRP_W-1:0]  conv_grp_o,
  output logic              sync_busy_o,
  output logic              partner_busy_o,
  output logic              partner_done_o,
  output logic              arb_block_o
);
  localparam int PW = CH_W + RES_W + EMUX_W + GRP_W;

  logic          load;
  logic          start;
  logic [PW-1:0] bundle_q;

  sync_slave_fsm u_fsm (
    .clk            (clk),
    .rst            (rst),
    .sreq_i         (sreq_i),
    .cancel_en_i    (cancel_en_i),
    .arb_req_i      (arb_req_i),
    .conv_done_i    (conv_done_i),
    .load_o         (load),
    .local_start_o  (local_start_o),
    .abort_o        (abort_o),
    .res_valid_o    (res_valid_o),
    .start_o        (start),
    .partner_done_o (partner_done_o),
    .sync_busy_o    (sync_busy_o),
    .partner_busy_o (partner_busy_o),
    .arb_block_o    (arb_block_o)
  );

  sync_req_latch #(.W(PW)) u_latch (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .d    ({chan_i, res_i, emux_i, grp_i}),
    .q    (bundle_q)
  );

  assign {conv_chan_o, conv_res_o, conv_emux_o, conv_grp_o} = bundle_q;
  assign ack_o        = start;
  assign conv_start_o = start;
endmodule

// File: rtl/sync_slave_chk.sv
module sync_slave_chk (
  input logic clk,
  input logic rst,
  input logic sreq_i,
  input logic conv_done_i,
  input logic local_start_o,
  input logic abort_o,
  input logic res_valid_o,
  input logic ack_o,
  input logic sync_busy_o,
  input logic partner_busy_o,
  input logic partner_done_o,
  input logic arb_block_o
);
  // R9
  ack_single_chk: assert property (@(posedge clk) disable iff (rst) ack_o |=> !ack_o);
  // R9
  ack_flags_chk: assert property (@(posedge clk) disable iff (rst) ack_o |-> partner_busy_o && !arb_block_o);
  // R8
  ack_live_chk: assert property (@(posedge clk) disable iff (rst) ack_o |-> $past(sreq_i));
  // R3
  no_local_in_sync_chk: assert property (@(posedge clk) disable iff (rst) local_start_o |-> !sync_busy_o);
  // R4
  abort_owner_chk: assert property (@(posedge clk) disable iff (rst) abort_o |-> sync_busy_o && !partner_busy_o && !res_valid_o);
  // R6
  sync_hold_chk: assert property (@(posedge clk) disable iff (rst) partner_busy_o && !conv_done_i |=> partner_busy_o);
  // R10
  done_clear_chk: assert property (@(posedge clk) disable iff (rst) partner_done_o |-> !partner_busy_o && !sync_busy_o);
  // R6
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst) $onehot0({local_start_o, abort_o, ack_o, partner_done_o}));
endmodule

bind sync_slave_ctrl sync_slave_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .sreq_i         (sreq_i),
  .conv_done_i    (conv_done_i),
  .local_start_o  (local_start_o),
  .abort_o        (abort_o),
  .res_valid_o    (res_valid_o),
  .ack_o          (ack_o),
  .sync_busy_o    (sync_busy_o),
  .partner_busy_o (partner_busy_o),
  .partner_done_o (partner_done_o),
  .arb_block_o    (arb_block_o)
);

// File: tb/sim_sync_slave_ctrl.sv
`timescale 1ns/1ps
module sim_sync_slave_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sreq = 0, cancel = 0, arb = 0, done = 0;
  logic [3:0] chan = 0;
  logic [1:0] res = 0;
  logic [2:0] emux = 0;
  logic [0:0] grp = 0;
  logic lstart, abrt, rval, ack, cstart, sbusy, pbusy, pdone, ablk;
  logic [3:0] o_chan;
  logic [1:0] o_res;
  logic [2:0] o_emux;
  logic [0:0] o_grp;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sync_slave_ctrl u0 (
    .clk(clk), .rst(rst), .sreq_i(sreq), .chan_i(chan), .res_i(res),
    .emux_i(emux), .grp_i(grp), .cancel_en_i(cancel), .arb_req_i(arb),
    .conv_done_i(done), .local_start_o(lstart), .abort_o(abrt),
    .res_valid_o(rval), .ack_o(ack), .conv_start_o(cstart),
    .conv_chan_o(o_chan), .conv_res_o(o_res), .conv_emux_o(o_emux),
    .conv_grp_o(o_grp), .sync_busy_o(sbusy), .partner_busy_o(pbusy),
    .partner_done_o(pdone), .arb_block_o(ablk)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic run_case(input int idx, input bit busy, input bit canc,
                          input bit wdraw, input int dly);
    int ech, ers, eem, egr;
    ech = (idx * 5 + 3) % 16;
    ers = idx % 4;
    eem = (idx * 3 + 1) % 8;
    egr = idx % 2;
    if (busy) begin
      arb = 1; cyc();
      chk("R3 local start", lstart, 1);
      arb = 0;
    end
    sreq = 1; cancel = canc;
    chan = 4'(ech); res = 2'(ers); emux = 3'(eem); grp = 1'(egr);
    arb = !busy;
    cyc();
    chk("R3 request beats arbitration", lstart, 0);
    chk("R7 busy on accept", sbusy, 1);
    chk("R3 block on accept", ablk, 1);
    chk("R4 abort on accept", abrt, (busy && canc) ? 1 : 0);
    chk("R9 no early ack", ack, 0);
    arb = 0;
    chan = 4'(~ech); res = 2'(~ers); emux = 3'(~eem); grp = 1'(~egr);
    if (busy && !canc) begin
      for (int k = 0; k < dly; k++) begin
        arb = 1; cyc();
        chk("R3 arbitration ignored", lstart, 0);
        chk("R5 no ack while waiting", ack, 0);
        chk("R3 block while waiting", ablk, 1);
      end
      arb = 0;
      if (wdraw) begin
        sreq = 0; cyc();
        chk("R8 busy clears on withdraw", sbusy, 0);
        chk("R8 no ack on withdraw", ack, 0);
        done = 1; cyc();
        chk("R8 local result after withdraw", rval, 1);
        done = 0; cyc();
        return;
      end
      done = 1; cyc();
      chk("R5 result delivered", rval, 1);
      chk("R5 no ack with result", ack, 0);
      done = 0;
    end else if (wdraw) begin
      sreq = 0; cyc();
      chk("R8 no ack on withdraw", ack, 0);
      chk("R8 busy clears", sbusy, 0);
      chk("R4 no result for aborted", rval, 0);
      return;
    end
    cyc();
    chk("R9 ack", ack, 1);
    chk("R9 start", cstart, 1);
    chk("R9 partner busy", pbusy, 1);
    chk("R9 block released", ablk, 0);
    chk("R4 no result for aborted", rval, 0);
    chk("R2 chan", o_chan, ech);
    chk("R2 res", o_res, ers);
    chk("R2 emux", o_emux, eem);
    chk("R2 grp", o_grp, egr);
    cancel = 1; arb = 1;
    for (int k = 0; k < 2; k++) begin
      cyc();
      chk("R9 single ack", ack, 0);
      chk("R6 no abort", abrt, 0);
      chk("R6 held busy", pbusy, 1);
    end
    sreq = 0; arb = 0; done = 1; cyc();
    chk("R10 done pulse", pdone, 1);
    chk("R10 partner clear", pbusy, 0);
    chk("R10 sync clear", sbusy, 0);
    done = 0; cyc();
    chk("R10 done single", pdone, 0);
  endtask

  initial begin
    int idx;
    idx = 0;
    repeat (3) cyc();
    chk("R1 ack", ack, 0);
    chk("R1 busy", sbusy, 0);
    chk("R1 pbusy", pbusy, 0);
    chk("R1 block", ablk, 0);
    chk("R1 chan", o_chan, 0);
    rst = 0;
    cyc();
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 2; c++)
        for (int w = 0; w < 2; w++)
          for (int d = 0; d < 3; d++) begin
            run_case(idx, b[0], c[0], w[0], d);
            idx++;
          end
    // R11: local end coincides with cancelling acceptance
    arb = 1; cyc(); arb = 0;
    sreq = 1; cancel = 1; done = 1; chan = 4'd9; cyc();
    chk("R11 result kept", rval, 1);
    chk("R11 no abort", abrt, 0);
    done = 0; cyc();
    chk("R11 start follows", ack, 1);
    chk("R11 chan", o_chan, 9);
    sreq = 0; done = 1; cyc();
    chk("R10 done after R11", pdone, 1);
    done = 0; cyc();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule